// File: doc/BRIEF.md
# Periodic Rate Generator and Interrupt Flag Unit

This block turns a 65536 Hz strobe into a periodic event whose rate is set by a 4-bit code. The strobe is one system-clock-cycle pulse for each half-period of a 32768 Hz crystal. Each periodic event sets a periodic flag. The same divider tap also drives an optional square-wave output at that rate with a 50 % duty cycle.

The periodic flag is held in a small flag register together with an alarm flag and an update-ended flag, which the timekeeping core sets with single-cycle pulses. Per-source enables from the host decide which flags raise the summary bit and the active-low interrupt line. A host read strobe clears every flag at the end of that cycle. A three-bit divider-control field can hold the divider chain in reset.

Top module: `periodic_irq_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `flag_reg` is 0x00, `irq_n` is 1, `sqw_out` is 0 and the divider count is zero.
- R2: For a rate code r from 1 to 15, with the divider running, the periodic flag (`flag_reg` bit 6) is set once every 2^r strobes. This gives 65536 >> r Hz. The first set follows the 2^r-th strobe after the divider leaves reset.
- R3: Rate code 0 produces no periodic event and keeps `sqw_out` low.
- R4: A `div_ctl` value of 3'b110 or 3'b111 clears the divider and holds it at zero. No periodic event occurs during the hold, and counting restarts from zero when the hold ends.
- R5: With `sqw_en` high and a nonzero rate code r, `sqw_out` is low for 2^(r-1) strobes and then high for 2^(r-1) strobes, counted from divider reset. With `sqw_en` low, `sqw_out` is low.
- R6: The periodic flag is set on every periodic event whatever the value of `pie`.
- R7: `flag_reg` has the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update-ended flag at bit 4. Bits 3:0 always read 0.
- R8: The summary bit is 1 in the cycle after an edge at which any flag with its enable (`pie`, `aie`, `uie`) was set.
- R9: `irq_n` is the inverse of the summary bit, and changes in the same cycle.
- R10: A cycle with `flag_rd` high clears all three flags at the following edge.
- R11: A flag event in the same cycle as `flag_rd` leaves its flag set after the clear.
- R12: A pulse on `alarm_evt` sets bit 5 and a pulse on `upd_evt` sets bit 4 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_stb | input | 1 | One-cycle strobe at 65536 Hz (each half-period of 32768 Hz) |
| div_ctl | input | 3 | Divider control; 3'b110 and 3'b111 hold the divider in reset |
| rate_sel | input | 4 | Rate code; 0 is off, 1 is fastest, 15 is 2 Hz |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | Alarm event pulse from the timekeeping core |
| upd_evt | input | 1 | Update-ended event pulse from the timekeeping core |
| flag_rd | input | 1 | Host read of the flag register; clears flags at the edge |
| flag_reg | output | 8 | Flag register view {summary, periodic, alarm, update, 4'b0} |
| irq_n | output | 1 | Active-low interrupt request |
| sqw_out | output | 1 | Square-wave output |

## Verification
The assertions assume that every input is stable and free of X from reset onward. They also assume that `base_stb`, `alarm_evt` and `upd_evt` are single-cycle pulses in the system clock domain. The bench drives every input on the falling edge from a value set before the first rising edge, so the block never samples a changing input. The strobe runs continuously, every other cycle, or at random, which covers back-to-back and sparse rates. The event, read and enable inputs are randomized only within those single-cycle pulse rules.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int unsigned BIT_SUM = 7;
  localparam int unsigned BIT_PER = 6;
  localparam int unsigned BIT_ALM = 5;
  localparam int unsigned BIT_UPD = 4;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } flag_set_t;

  // Divider held in reset for control codes with the two upper bits set.
  function automatic logic hold_code(input logic [2:0] ctl);
    return ctl[2] & ctl[1];
  endfunction

endpackage

// File: rtl/pirq_divider.sv
module pirq_divider #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  always_comb begin
    if (hold)     cnt_d = '0;
    else if (stb) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0));

endmodule

// File: rtl/pirq_tap.sv
module pirq_tap #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              hold,
  input  logic [RATE_W-1:0] rate,
  input  logic              sqw_en,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic              tick,
  output logic              sqw_q
);

  localparam int unsigned NCODE = 2 ** RATE_W;

  logic [NCODE-1:0] wrap_vec;
  logic [NCODE-1:0] lvl_vec;

  assign wrap_vec[0] = 1'b0;
  assign lvl_vec[0]  = 1'b0;

  generate
    for (genvar r = 1; r < NCODE; r++) begin : g_code
      if (r <= CNT_W) begin : g_live
        assign wrap_vec[r] = &cnt_q[r-1:0];
        assign lvl_vec[r]  = cnt_d[r-1];
      end else begin : g_dead
        assign wrap_vec[r] = 1'b0;
        assign lvl_vec[r]  = 1'b0;
      end
    end
  endgenerate

  assign tick = stb & ~hold & wrap_vec[rate];

  always_ff @(posedge clk) begin
    if (rst) sqw_q <= 1'b0;
    else     sqw_q <= sqw_en & lvl_vec[rate];
  end

  // R2
  tick_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> stb);

  // R5
  sqw_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_q);

  // R3
  rate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |=> !sqw_q);

endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank
  import pirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      alm_evt,
  input  logic      upd_evt,
  input  logic      rd,
  input  logic      pie,
  input  logic      aie,
  input  logic      uie,
  output flag_set_t flg_q,
  output logic      sum_q,
  output logic      irq_n_q
);

  flag_set_t flg_d;
  logic      sum_d;

  always_comb begin
    flg_d.per = (flg_q.per & ~rd) | tick;
    flg_d.alm = (flg_q.alm & ~rd) | alm_evt;
    flg_d.upd = (flg_q.upd & ~rd) | upd_evt;
    sum_d     = (flg_d.per & pie) | (flg_d.alm & aie) | (flg_d.upd & uie);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q   <= '0;
      sum_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      flg_q   <= flg_d;
      sum_q   <= sum_d;
      irq_n_q <= ~sum_d;
    end
  end

  // R8
  sum_src_chk: assert property (@(posedge clk) disable iff (rst)
    sum_q |-> (flg_q.per | flg_q.alm | flg_q.upd));

  // R11
  alm_kept_chk: assert property (@(posedge clk) disable iff (rst)
    alm_evt |=> flg_q.alm);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !alm_evt && !upd_evt) |=> (!flg_q.alm && !flg_q.upd));

  // R6
  per_set_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> flg_q.per);

endmodule

// File: rtl/periodic_irq_unit.sv
module periodic_irq_unit
  import pirq_pkg::*;
#(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_stb,
  input  logic [2:0]        div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie,
  input  logic              aie,
  input  logic              uie,
  input  logic              sqw_en,
  input  logic              alarm_evt,
  input  logic              upd_evt,
  input  logic              flag_rd,
  output logic [7:0]        flag_reg,
  output logic              irq_n,
  output logic              sqw_out
);

  logic             hold;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             tick;
  flag_set_t        flg_q;
  logic             sum_q;

  assign hold = hold_code(div_ctl);

  pirq_divider #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .stb   (base_stb),
    .hold  (hold),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  pirq_tap #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_tap (
    .clk    (clk),
    .rst    (rst),
    .stb    (base_stb),
    .hold   (hold),
    .rate   (rate_sel),
    .sqw_en (sqw_en),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d),
    .tick   (tick),
    .sqw_q  (sqw_out)
  );

  pirq_flag_bank u_flags (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .alm_evt (alarm_evt),
    .upd_evt (upd_evt),
    .rd      (flag_rd),
    .pie     (pie),
    .aie     (aie),
    .uie     (uie),
    .flg_q   (flg_q),
    .sum_q   (sum_q),
    .irq_n_q (irq_n)
  );

  always_comb begin
    flag_reg          = '0;
    flag_reg[BIT_SUM] = sum_q;
    flag_reg[BIT_PER] = flg_q.per;
    flag_reg[BIT_ALM] = flg_q.alm;
    flag_reg[BIT_UPD] = flg_q.upd;
  end

  // R9
  irq_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_reg[BIT_SUM] == 1'b0) |-> irq_n);

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !sqw_out);

endmodule

// File: tb/periodic_irq_unit_tb_top.sv
module periodic_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_stb = 1'b0;
  logic [2:0] div_ctl = 3'b010;
  logic [3:0] rate_sel = 4'd0;
  logic       pie = 1'b0, aie = 1'b0, uie = 1'b0, sqw_en = 1'b0;
  logic       alarm_evt = 1'b0, upd_evt = 1'b0, flag_rd = 1'b0;
  logic [7:0] flag_reg;
  logic       irq_n, sqw_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_pf = 0, m_af = 0, m_uf = 0, m_sum = 0, m_sqw = 0;

  always #5 clk = ~clk;

  periodic_irq_unit dut_i (
    .clk(clk), .rst(rst), .base_stb(base_stb), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .pie(pie), .aie(aie), .uie(uie), .sqw_en(sqw_en),
    .alarm_evt(alarm_evt), .upd_evt(upd_evt), .flag_rd(flag_rd),
    .flag_reg(flag_reg), .irq_n(irq_n), .sqw_out(sqw_out)
  );

  always @(posedge clk) begin
    bit hold_m, tk;
    int k;
    if (rst) begin
      m_cnt = 0; m_pf = 0; m_af = 0; m_uf = 0; m_sum = 0; m_sqw = 0;
    end else begin
      hold_m = div_ctl[2] && div_ctl[1];
      k = int'(rate_sel);
      tk = base_stb && !hold_m && k != 0 && ((m_cnt % (1 << k)) == (1 << k) - 1);
      if (hold_m) m_cnt = 0;
      else if (base_stb) m_cnt = (m_cnt + 1) % 32768;
      m_pf  = (flag_rd ? 1'b0 : m_pf) | tk;
      m_af  = (flag_rd ? 1'b0 : m_af) | alarm_evt;
      m_uf  = (flag_rd ? 1'b0 : m_uf) | upd_evt;
      m_sum = (m_pf && pie) || (m_af && aie) || (m_uf && uie);
      m_sqw = sqw_en && k != 0 && (((m_cnt >> (k - 1)) & 1) == 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(flag_reg[6] == m_pf,  "R2 periodic flag", flag_reg[6], m_pf);
      check(flag_reg[5] == m_af,  "R12 alarm flag",   flag_reg[5], m_af);
      check(flag_reg[4] == m_uf,  "R12 update flag",  flag_reg[4], m_uf);
      check(flag_reg[7] == m_sum, "R8 summary bit",   flag_reg[7], m_sum);
      check(irq_n == !m_sum,      "R9 irq line",      irq_n, !m_sum);
      check(sqw_out == m_sqw,     "R5 square wave",   sqw_out, m_sqw);
      check(flag_reg[3:0] == 4'h0, "R7 low bits",     flag_reg[3:0], 0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rd();
    flag_rd = 1'b1; cyc(1); flag_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(flag_reg == 8'h00 && irq_n && !sqw_out, "R1 reset", {flag_reg, irq_n, sqw_out}, 10'h002);
    @(negedge clk); rst = 1'b0;
    cyc(1);
    check(flag_reg == 8'h00 && irq_n && !sqw_out, "R1 after reset", {flag_reg, irq_n, sqw_out}, 10'h002);

    // R2/R6: code 3, strobe every cycle, periodic enable off
    rate_sel = 4'd3; sqw_en = 1'b1; base_stb = 1'b1;
    cyc(7);
    check(flag_reg[6] == 1'b0, "R2 before 8th strobe", flag_reg[6], 0);
    cyc(1);
    check(flag_reg[6] == 1'b1, "R2 after 8th strobe", flag_reg[6], 1);
    check(irq_n == 1'b1, "R6 flag set with pie low, irq quiet", irq_n, 1);
    cyc(90);
    pie = 1'b1; cyc(2);
    check(irq_n == 1'b0, "R9 irq with pie", irq_n, 0);
    pulse_rd();

    // fastest code, then sparse strobe
    rate_sel = 4'd1; cyc(20);
    rate_sel = 4'd4;
    for (int i = 0; i < 120; i++) begin base_stb = i[0]; cyc(1); end
    base_stb = 1'b1;

    // R3: code 0
    rate_sel = 4'd0; pulse_rd(); cyc(64);
    check(flag_reg[6] == 1'b0 && !sqw_out, "R3 code zero silent", {flag_reg[6], sqw_out}, 0);

    // R12/R10/R11
    pie = 1'b0;
    alarm_evt = 1'b1; cyc(1); alarm_evt = 1'b0;
    upd_evt = 1'b1; cyc(1); upd_evt = 1'b0;
    check(flag_reg[5:4] == 2'b11, "R12 events set flags", flag_reg[5:4], 3);
    pulse_rd();
    check(flag_reg[6:4] == 3'b000, "R10 read clears", flag_reg[6:4], 0);
    alarm_evt = 1'b1; flag_rd = 1'b1; cyc(1); alarm_evt = 1'b0; flag_rd = 1'b0;
    check(flag_reg[5] == 1'b1, "R11 event kept over read", flag_reg[5], 1);
    aie = 1'b1; cyc(1);
    check(flag_reg[7] == 1'b1 && irq_n == 1'b0, "R8 summary from alarm", {flag_reg[7], irq_n}, 2);
    aie = 1'b0; pulse_rd();

    // R4: divider hold
    rate_sel = 4'd2; div_ctl = 3'b110; pulse_rd(); cyc(10);
    check(flag_reg[6] == 1'b0 && !sqw_out, "R4 hold 110 silent", {flag_reg[6], sqw_out}, 0);
    div_ctl = 3'b111; cyc(10);
    check(flag_reg[6] == 1'b0, "R4 hold 111 silent", flag_reg[6], 0);
    div_ctl = 3'b010; cyc(3);
    check(flag_reg[6] == 1'b0, "R4 restart from zero", flag_reg[6], 0);
    cyc(1);
    check(flag_reg[6] == 1'b1, "R4 first tick after release", flag_reg[6], 1);

    // R5: square wave disabled
    sqw_en = 1'b0; cyc(10);
    check(!sqw_out, "R5 square wave disabled", sqw_out, 0);
    sqw_en = 1'b1;

    // slowest code over a full period
    rate_sel = 4'd15; div_ctl = 3'b110; cyc(1); div_ctl = 3'b010; pulse_rd();
    cyc(33000);

    // randomized mix
    for (int i = 0; i < 3000; i++) begin
      rate_sel  = 4'($urandom_range(0, 6));
      base_stb  = 1'($urandom);
      alarm_evt = ($urandom_range(0, 15) == 0);
      upd_evt   = ($urandom_range(0, 15) == 0);
      flag_rd   = ($urandom_range(0, 7) == 0);
      pie = 1'($urandom); aie = 1'($urandom); uie = 1'($urandom);
      sqw_en    = 1'($urandom);
      div_ctl   = ($urandom_range(0, 31) == 0) ? 3'b110 : 3'b010;
      cyc(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule